// File: doc/BRIEF.md
# Serial Peripheral Control/Status Register Block

This block is the software-visible register file of a serial peripheral controller, with no shifter behind it. It holds seven 16-bit registers: control, flag, status, transmit data, receive data, baud and shadow. Software reaches them over a simple synchronous bus that has a separate write channel and a separate read channel. Each channel carries an enable, a byte address, an access-size code and data. Each channel returns a two-bit error code in the same cycle as the access, and the read channel returns its data in that same cycle.

A stub stands in for the serial engine. The transmit-ready and receive-ready flags in the status register move as side effects of data-register accesses. A transmit-data write marks a word as received. A receive-data read empties both flags. Each side effect applies only when control enables the peripheral and its mode field selects the matching transfer-initiation style. The status register also appears on a dedicated output port. Any access of the wrong size, or to an unmapped offset, is refused and changes nothing. A size fault is reported ahead of an address fault.

Top module: `spi_regblk`

## Requirements
- R1: Registers sit at byte offsets 0x00 control, 0x04 flag, 0x08 status, 0x0C transmit data, 0x10 receive data, 0x14 baud and 0x18 shadow. Control, flag, transmit data, receive data, baud and shadow read back the last value written to them.
- R2: Only size code 2'b01 (16-bit) is legal. Any other size returns error code 2'b01, even when the offset is also unmapped.
- R3: A legal-size access to an offset of 0x1C or above, or to an offset that is not a multiple of 4, returns error code 2'b10. A good access returns 2'b00. A refused write changes no register.
- R4: After reset, control reads 0x0400, flag reads 0xFF00 and status reads 0x0001. Every other register reads 0x0000.
- R5: A write to status clears each status bit whose written bit is 1. The exceptions are bit 0 (shift-done), bit 3 (transmit-ready) and bit 5 (receive-ready), which a status write never changes.
- R6: This requirement applies when control bit 14 (enable) is 1 and control bits [1:0] are 2'b01 (transmit-initiated). A good write to transmit data then sets status bit 5 and clears status bit 3.
- R7: This requirement applies when control bit 14 is 1 and control bits [1:0] are 2'b00 (receive-initiated). A good read of receive data then clears status bits 5 and 3.
- R8: Status is left unchanged in the following cases:
  - a read of any register other than receive data;
  - a transmit-data write while not enabled in transmit-initiated mode;
  - a receive-data read while not enabled in receive-initiated mode.
- R9: A refused read returns 0x0000 on the read data.
- R10: The status output port always equals the status register value.
- R11: The side effects of R6 and R7 are gated by the control value held before the cycle. A control write in the same cycle affects only later accesses.
- R12: A write and a read in the same cycle both take effect. A read of a register that is being written in that cycle returns the value it held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write access request |
| wr_addr | input | ADDR_W | Write byte offset |
| wr_size | input | 2 | Write size code (2'b01 = 16-bit) |
| wr_data | input | 16 | Write data |
| wr_err | output | 2 | Write error code (00 ok, 01 size, 10 address) |
| rd_en | input | 1 | Read access request |
| rd_addr | input | ADDR_W | Read byte offset |
| rd_size | input | 2 | Read size code (2'b01 = 16-bit) |
| rd_data | output | 16 | Read data, zero when refused or idle |
| rd_err | output | 2 | Read error code (00 ok, 01 size, 10 address) |
| status_o | output | 16 | Live copy of the status register |

## Verification
Both channels can act on the status register in the same cycle, so a receive-data read that empties the ready flags can meet a status write or a control write. The bench sets the receive-ready flag and then issues both pairs as single cycles. In the first pair, a status write of all ones meets a clearing receive-data read, and the expected outcome is that only the read's clear is seen. In the second pair, a control write that changes mode meets a receive-data read, and the expected outcome is that the old mode decides the gating. A read of a register written in the same cycle is judged to return the old value.

// File: rtl/spi_regblk_pkg.sv
package spi_regblk_pkg;
  localparam int REG_W = 16;
  localparam int NREG  = 7;
  localparam int IDX_W = $clog2(NREG);

  localparam int IDX_CTL  = 0;
  localparam int IDX_FLG  = 1;
  localparam int IDX_STAT = 2;
  localparam int IDX_TX   = 3;
  localparam int IDX_RX   = 4;
  localparam int IDX_BAUD = 5;
  localparam int IDX_SHDW = 6;

  localparam int EN_BIT   = 14;
  localparam int SPIF_BIT = 0;
  localparam int TXS_BIT  = 3;
  localparam int RXS_BIT  = 5;

  localparam logic [1:0] MODE_RX   = 2'b00;
  localparam logic [1:0] MODE_TX   = 2'b01;
  localparam logic [1:0] SIZE_HALF = 2'b01;

  localparam logic [1:0] ERR_NONE = 2'b00;
  localparam logic [1:0] ERR_SIZE = 2'b01;
  localparam logic [1:0] ERR_ADDR = 2'b10;

  localparam logic [REG_W-1:0] PROT_MASK =
    REG_W'((1 << SPIF_BIT) | (1 << TXS_BIT) | (1 << RXS_BIT));

  function automatic logic [REG_W-1:0] reset_value(input int idx);
    case (idx)
      IDX_CTL:  reset_value = 16'h0400;
      IDX_FLG:  reset_value = 16'hFF00;
      IDX_STAT: reset_value = 16'h0001;
      default:  reset_value = '0;
    endcase
  endfunction
endpackage

// File: rtl/spi_regblk_decode.sv
module spi_regblk_decode
  import spi_regblk_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output logic              hit,
  output logic [IDX_W-1:0]  idx,
  output logic [1:0]        err
);
  localparam int SLOT_W = ADDR_W - 2;

  logic [SLOT_W-1:0] slot;
  logic              aligned;
  logic              mapped;
  logic              size_ok;

  assign slot    = addr[ADDR_W-1:2];
  assign aligned = (addr[1:0] == 2'b00);
  assign mapped  = aligned && (slot < SLOT_W'(NREG));
  assign size_ok = (size == SIZE_HALF);
  assign idx     = slot[IDX_W-1:0];

  always_comb begin
    err = ERR_NONE;
    if (en) begin
      if (!size_ok)     err = ERR_SIZE;
      else if (!mapped) err = ERR_ADDR;
    end
  end

  assign hit = en && size_ok && mapped;

  always_comb begin
    if (hit) assert (err == ERR_NONE) else $error("AST_HIT_NO_ERR"); // R3
  end
endmodule

// File: rtl/spi_regblk_status.sv
module spi_regblk_status
  import spi_regblk_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             stat_wr,
  input  logic [REG_W-1:0] wdata,
  input  logic             tx_push,
  input  logic             rx_pop,
  input  logic [REG_W-1:0] ctl,
  output logic [REG_W-1:0] stat
);
  logic             enabled;
  logic             tx_fire;
  logic             rx_fire;
  logic [REG_W-1:0] stat_nxt;

  assign enabled = ctl[EN_BIT];
  assign tx_fire = tx_push && enabled && (ctl[1:0] == MODE_TX);
  assign rx_fire = rx_pop  && enabled && (ctl[1:0] == MODE_RX);

  always_comb begin
    stat_nxt = stat;
    if (stat_wr) stat_nxt = stat_nxt & ~(wdata & ~PROT_MASK);
    if (tx_fire) begin
      stat_nxt[RXS_BIT] = 1'b1;
      stat_nxt[TXS_BIT] = 1'b0;
    end
    if (rx_fire) begin
      stat_nxt[RXS_BIT] = 1'b0;
      stat_nxt[TXS_BIT] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) stat <= reset_value(IDX_STAT);
    else     stat <= stat_nxt;
  end

  AST_PROT_HOLD: assert property (@(posedge clk) disable iff (rst)
    stat_wr && !tx_push && !rx_pop |=> $stable(stat & PROT_MASK)) else $error("AST_PROT_HOLD"); // R5
  AST_TX_MARK: assert property (@(posedge clk) disable iff (rst)
    tx_push && ctl[EN_BIT] && ctl[1:0] == MODE_TX |=> stat[RXS_BIT] && !stat[TXS_BIT]) else $error("AST_TX_MARK"); // R6
  AST_RX_EMPTY: assert property (@(posedge clk) disable iff (rst)
    rx_pop && ctl[EN_BIT] && ctl[1:0] == MODE_RX |=> !stat[RXS_BIT] && !stat[TXS_BIT]) else $error("AST_RX_EMPTY"); // R7
  AST_FLAGS_IDLE: assert property (@(posedge clk) disable iff (rst)
    !stat_wr && !tx_push && !rx_pop |=> $stable(stat)) else $error("AST_FLAGS_IDLE"); // R8
endmodule

// File: rtl/spi_regblk_file.sv
module spi_regblk_file
  import spi_regblk_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_hit,
  input  logic [IDX_W-1:0]           wr_idx,
  input  logic [REG_W-1:0]           wr_data,
  input  logic [REG_W-1:0]           stat_in,
  output logic [NREG-1:0][REG_W-1:0] view
);
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (i == IDX_STAT) begin : g_stat
      assign view[i] = stat_in;
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (rst)                                  view[i] <= reset_value(i);
        else if (wr_hit && wr_idx == IDX_W'(i))   view[i] <= wr_data;
      end
    end
  end
endmodule

// File: rtl/spi_regblk.sv
module spi_regblk
  import spi_regblk_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [1:0]        wr_size,
  input  logic [15:0]       wr_data,
  output logic [1:0]        wr_err,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [1:0]        rd_size,
  output logic [15:0]       rd_data,
  output logic [1:0]        rd_err,
  output logic [15:0]       status_o
);
  logic                       wr_hit, rd_hit;
  logic [IDX_W-1:0]           wr_idx, rd_idx;
  logic [REG_W-1:0]           stat;
  logic [NREG-1:0][REG_W-1:0] view;

  spi_regblk_decode #(.ADDR_W(ADDR_W)) u_wdec (
    .en(wr_en), .addr(wr_addr), .size(wr_size),
    .hit(wr_hit), .idx(wr_idx), .err(wr_err)
  );

  spi_regblk_decode #(.ADDR_W(ADDR_W)) u_rdec (
    .en(rd_en), .addr(rd_addr), .size(rd_size),
    .hit(rd_hit), .idx(rd_idx), .err(rd_err)
  );

  spi_regblk_status u_stat (
    .clk(clk), .rst(rst),
    .stat_wr(wr_hit && wr_idx == IDX_W'(IDX_STAT)),
    .wdata(wr_data),
    .tx_push(wr_hit && wr_idx == IDX_W'(IDX_TX)),
    .rx_pop(rd_hit && rd_idx == IDX_W'(IDX_RX)),
    .ctl(view[IDX_CTL]),
    .stat(stat)
  );

  spi_regblk_file u_file (
    .clk(clk), .rst(rst),
    .wr_hit(wr_hit), .wr_idx(wr_idx), .wr_data(wr_data),
    .stat_in(stat), .view(view)
  );

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NREG; i++) begin
      if (rd_hit && rd_idx == IDX_W'(i)) rd_data = view[i];
    end
  end

  assign status_o = stat;

  AST_RD_ZERO: assert property (@(posedge clk) disable iff (rst)
    rd_err != ERR_NONE |-> rd_data == '0) else $error("AST_RD_ZERO"); // R9
  AST_SIZE_FIRST: assert property (@(posedge clk) disable iff (rst)
    rd_en && rd_size != SIZE_HALF |-> rd_err == ERR_SIZE) else $error("AST_SIZE_FIRST"); // R2
  AST_BAD_WR_HOLD: assert property (@(posedge clk) disable iff (rst)
    wr_en && wr_err != ERR_NONE && !rd_en |=> $stable(view)) else $error("AST_BAD_WR_HOLD"); // R3
  AST_STAT_PORT: assert property (@(posedge clk) disable iff (rst)
    1'b1 |-> status_o == view[IDX_STAT]) else $error("AST_STAT_PORT"); // R10
endmodule

// File: tb/spi_regblk_tb.sv
module spi_regblk_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [4:0]  wr_addr = '0, rd_addr = '0;
  logic [1:0]  wr_size = 2'b01, rd_size = 2'b01;
  logic [15:0] wr_data = '0;
  logic [1:0]  wr_err, rd_err;
  logic [15:0] rd_data, status_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [15:0] s_rdata;
  logic [1:0]  s_werr, s_rerr;

  always #2 clk = ~clk;

  spi_regblk u_dut (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_size(wr_size), .wr_data(wr_data), .wr_err(wr_err),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_size(rd_size), .rd_data(rd_data), .rd_err(rd_err),
    .status_o(status_o)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic we, input logic [4:0] wa, input logic [1:0] ws, input logic [15:0] wd,
                     input logic re, input logic [4:0] ra, input logic [1:0] rs);
    @(negedge clk);
    wr_en = we; wr_addr = wa; wr_size = ws; wr_data = wd;
    rd_en = re; rd_addr = ra; rd_size = rs;
    #1;
    s_rdata = rd_data; s_werr = wr_err; s_rerr = rd_err;
    @(posedge clk);
    #1;
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    cyc(1'b1, a, 2'b01, d, 1'b0, 5'h0, 2'b01);
  endtask

  task automatic rd(input logic [4:0] a);
    cyc(1'b0, 5'h0, 2'b01, 16'h0, 1'b1, a, 2'b01);
  endtask

  task automatic t_reset;
    rd(5'h00); chk("R4 ctl", s_rdata, 16'h0400);
    rd(5'h04); chk("R4 flag", s_rdata, 16'hFF00);
    rd(5'h08); chk("R4 stat", s_rdata, 16'h0001);
    rd(5'h0C); chk("R4 tx", s_rdata, 16'h0000);
    rd(5'h10); chk("R4 rx", s_rdata, 16'h0000);
    rd(5'h14); chk("R4 baud", s_rdata, 16'h0000);
    rd(5'h18); chk("R4 shadow", s_rdata, 16'h0000);
    chk("R10 port at reset", status_o, 16'h0001);
  endtask

  task automatic t_rw;
    wr(5'h04, 16'h1357); wr(5'h0C, 16'hA5A5); wr(5'h10, 16'h5A5A);
    wr(5'h14, 16'h00C8); wr(5'h18, 16'hBEEF);
    chk("R3 good write code", {14'h0, s_werr}, 16'h0000);
    rd(5'h04); chk("R1 flag", s_rdata, 16'h1357);
    rd(5'h0C); chk("R1 tx", s_rdata, 16'hA5A5);
    rd(5'h10); chk("R1 rx", s_rdata, 16'h5A5A);
    rd(5'h14); chk("R1 baud", s_rdata, 16'h00C8);
    rd(5'h18); chk("R1 shadow", s_rdata, 16'hBEEF);
    chk("R8 stat after plain rw", status_o, 16'h0001);
  endtask

  task automatic t_size;
    cyc(1'b0, 5'h0, 2'b01, 16'h0, 1'b1, 5'h14, 2'b00);
    chk("R2 byte read code", {14'h0, s_rerr}, 16'h0001);
    chk("R9 byte read data", s_rdata, 16'h0000);
    cyc(1'b0, 5'h0, 2'b01, 16'h0, 1'b1, 5'h1C, 2'b10);
    chk("R2 size beats addr", {14'h0, s_rerr}, 16'h0001);
    cyc(1'b1, 5'h14, 2'b10, 16'hDEAD, 1'b0, 5'h0, 2'b01);
    chk("R2 word write code", {14'h0, s_werr}, 16'h0001);
    rd(5'h14); chk("R3 baud after bad size", s_rdata, 16'h00C8);
  endtask

  task automatic t_addr;
    rd(5'h1C);
    chk("R3 unmapped read code", {14'h0, s_rerr}, 16'h0002);
    chk("R9 unmapped read data", s_rdata, 16'h0000);
    wr(5'h16, 16'h7777);
    chk("R3 misaligned write code", {14'h0, s_werr}, 16'h0002);
    wr(5'h1E, 16'h7777);
    chk("R3 high write code", {14'h0, s_werr}, 16'h0002);
    rd(5'h14); chk("R3 baud kept", s_rdata, 16'h00C8);
    rd(5'h18); chk("R3 shadow kept", s_rdata, 16'hBEEF);
  endtask

  task automatic t_tx;
    wr(5'h00, 16'h0001);
    wr(5'h0C, 16'h1111);
    chk("R8 tx write disabled", status_o, 16'h0001);
    wr(5'h00, 16'h4001);
    wr(5'h0C, 16'h2222);
    chk("R6 tx write sets rxs", status_o, 16'h0021);
    rd(5'h10);
    chk("R8 rx read in tx mode", status_o, 16'h0021);
    rd(5'h0C); rd(5'h00);
    chk("R8 other reads", status_o, 16'h0021);
    wr(5'h08, 16'hFFFF);
    rd(5'h08); chk("R5 w1c protected", s_rdata, 16'h0021);
  endtask

  task automatic t_rx;
    wr(5'h00, 16'h4000);
    rd(5'h10);
    chk("R7 rx read clears", status_o, 16'h0001);
    wr(5'h0C, 16'h3333);
    chk("R8 tx write in rx mode", status_o, 16'h0001);
  endtask

  task automatic t_old_ctl;
    wr(5'h00, 16'h4001); wr(5'h0C, 16'h4444);
    chk("R6 rearm", status_o, 16'h0021);
    cyc(1'b1, 5'h00, 2'b01, 16'h4000, 1'b1, 5'h10, 2'b01);
    chk("R11 old mode gates", status_o, 16'h0021);
    rd(5'h10);
    chk("R11 new mode later", status_o, 16'h0001);
  endtask

  task automatic t_both;
    wr(5'h00, 16'h4001); wr(5'h0C, 16'h5555);
    wr(5'h00, 16'h4000);
    cyc(1'b1, 5'h08, 2'b01, 16'hFFFF, 1'b1, 5'h10, 2'b01);
    chk("R12 w1c plus rx clear", status_o, 16'h0001);
    cyc(1'b1, 5'h10, 2'b01, 16'h9876, 1'b1, 5'h10, 2'b01);
    chk("R12 read old value", s_rdata, 16'h5A5A);
    rd(5'h10); chk("R12 write landed", s_rdata, 16'h9876);
    wr(5'h00, 16'h4001);
    cyc(1'b1, 5'h0C, 2'b01, 16'h6666, 1'b1, 5'h10, 2'b01);
    chk("R12 tx with rx read", status_o, 16'h0021);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_rw();
    t_size();
    t_addr();
    t_tx();
    t_rx();
    t_old_ctl();
    t_both();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule